// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block holds the eight status flags of a serial communications interface and turns them into transmitter and receiver interrupt requests. The transmit and receive datapaths report single-cycle event strobes: a character handed from the transmit data register to the shift register, a received word moved into the receive data register (with its noise, framing and parity qualifiers), a receive overrun and an idle line. A level input reports that the transmitter has data, preamble or break queued or in flight. The CPU side is represented by three access strobes: status register read, data register read and data register write.

Every flag except transmission-complete is sticky. Software clears it with a two-step sequence: first read the status register while the flag is set, then access the data register. Transmitter-empty needs a data write. The receive-side flags need a data read. Transmission-complete is never stored: it is transmitter-empty qualified by an idle transmitter.

Each sticky flag is a three-state machine. FLG_CLEAR holds the flag at 0. FLG_SET holds it at 1 and waits for a status read. FLG_ARMED holds it at 1 after a status read and waits for the matching data access. The transitions are:
- set event: any state to FLG_SET. It has priority over everything else.
- status read: FLG_SET to FLG_ARMED.
- matching data access: FLG_ARMED to FLG_CLEAR.
- status read while in FLG_ARMED: stays in FLG_ARMED.

Any other input leaves the state as it is.

Top module: `uart_status_flags`

## Requirements
- R1: The status byte is {tx_empty[7], tx_done[6], rx_full[5], rx_idle[4], overrun[3], noise[2], frame_err[1], parity_err[0]}. After reset it reads 8'hC0 while tx_active is low: transmitter-empty and transmission-complete are set, all others are clear.
- R2: A tx_handoff strobe sets bit 7 in the following cycle.
- R3: Bit 7 clears on the cycle after a data write, but only if a status read saw bit 7 set earlier. A data read never clears it.
- R4: Bit 6 is 1 exactly when bit 7 is 1 and tx_active is low. It drops in the same cycle that tx_active rises.
- R5: An rx_load strobe sets bit 5 in the following cycle. It also sets bits 2, 1 and 0 when rx_noise, rx_frame_err and rx_parity_err are high with it. Those qualifiers have no effect without rx_load.
- R6: An rx_idle_det strobe sets bit 4 and an rx_overrun strobe sets bit 3, each in the following cycle.
- R7: Bits 5 to 0 each clear on the cycle after a data read, but only if a status read saw that bit set earlier. A data write never clears them.
- R8: A data register access with no earlier qualifying status read leaves every flag unchanged.
- R9: A set event for a flag wins over a same-cycle data access or status read. The flag stays set and returns to the not-yet-read state, so a later data access does not clear it until a new status read has seen it.
- R10: tx_irq is high when (bit 7 and ie_tx_empty) or (bit 6 and ie_tx_done).
- R11: rx_irq is high when (bit 5 and ie_rx_full) or (bit 4 and ie_rx_idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_handoff | input | 1 | Strobe: transmit data register handed its character to the shift register |
| tx_active | input | 1 | Level: data, preamble or break queued or being shifted |
| rx_load | input | 1 | Strobe: received word moved to the receive data register |
| rx_noise | input | 1 | Noise qualifier for rx_load |
| rx_frame_err | input | 1 | Framing-error qualifier for rx_load |
| rx_parity_err | input | 1 | Parity-error qualifier for rx_load |
| rx_overrun | input | 1 | Strobe: receive overrun |
| rx_idle_det | input | 1 | Strobe: idle line detected |
| stat_rd | input | 1 | CPU read of the status register |
| data_rd | input | 1 | CPU read of the data register |
| data_wr | input | 1 | CPU write of the data register |
| ie_tx_empty | input | 1 | Interrupt enable for bit 7 |
| ie_tx_done | input | 1 | Interrupt enable for bit 6 |
| ie_rx_full | input | 1 | Interrupt enable for bit 5 |
| ie_rx_idle | input | 1 | Interrupt enable for bit 4 |
| status | output | 8 | Status byte |
| tx_irq | output | 1 | Transmitter interrupt request |
| rx_irq | output | 1 | Receiver interrupt request |

## Verification
The hardest case to reach is a new event landing on a flag that is already in FLG_ARMED, in the same cycle as the data access that would otherwise clear it. The stimulus first arms the flags with a status read. It then pulses rx_load together with data_rd. Afterwards parity_err must clear while rx_full must stay set. A further bare data read must leave rx_full set, which shows the arm was dropped. A second sequence pulses rx_load in the same cycle as a status read, starting from a clear flag, and checks that the following data read leaves the flag set.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_TXE  = 7;
    localparam int BIT_TXC  = 6;
    localparam int BIT_RXF  = 5;
    localparam int BIT_IDLE = 4;
    localparam int BIT_OVR  = 3;
    localparam int BIT_NZ   = 2;
    localparam int BIT_FRM  = 1;
    localparam int BIT_PAR  = 0;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'b00,
        FLG_SET   = 2'b01,
        FLG_ARMED = 2'b10
    } flag_state_e;
endpackage

// File: rtl/uart_stat_flag_cell.sv
module uart_stat_flag_cell
    import uart_stat_pkg::*;
#(
    parameter bit RST_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic clr_access,
    output logic flag
);
    localparam flag_state_e RST_STATE = RST_SET ? FLG_SET : FLG_CLEAR;

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (set_evt) begin
            state_d = FLG_SET;
        end else begin
            unique case (state_q)
                FLG_CLEAR: state_d = FLG_CLEAR;
                FLG_SET:   if (stat_rd) state_d = FLG_ARMED;
                FLG_ARMED: if (clr_access) state_d = FLG_CLEAR;
                default:   state_d = FLG_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag = (state_q != FLG_CLEAR);
    end
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
    import uart_stat_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    input  logic              ie_tx_empty,
    input  logic              ie_tx_done,
    input  logic              ie_rx_full,
    input  logic              ie_rx_idle,
    output logic              tx_irq,
    output logic              rx_irq
);
    always_comb begin
        tx_irq = (status[BIT_TXE] & ie_tx_empty) | (status[BIT_TXC] & ie_tx_done);
        rx_irq = (status[BIT_RXF] & ie_rx_full)  | (status[BIT_IDLE] & ie_rx_idle);
    end
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_handoff,
    input  logic              tx_active,
    input  logic              rx_load,
    input  logic              rx_noise,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              rx_overrun,
    input  logic              rx_idle_det,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              ie_tx_empty,
    input  logic              ie_tx_done,
    input  logic              ie_rx_full,
    input  logic              ie_rx_idle,
    output logic [STAT_W-1:0] status,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] flag_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_TXE]  = tx_handoff;
        set_vec[BIT_RXF]  = rx_load;
        set_vec[BIT_IDLE] = rx_idle_det;
        set_vec[BIT_OVR]  = rx_overrun;
        set_vec[BIT_NZ]   = rx_load & rx_noise;
        set_vec[BIT_FRM]  = rx_load & rx_frame_err;
        set_vec[BIT_PAR]  = rx_load & rx_parity_err;
        clr_vec           = {STAT_W{data_rd}};
        clr_vec[BIT_TXE]  = data_wr;
        clr_vec[BIT_TXC]  = 1'b0;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        if (i == BIT_TXC) begin : g_derived
            assign flag_vec[i] = flag_vec[BIT_TXE] & ~tx_active;
        end else begin : g_sticky
            uart_stat_flag_cell #(
                .RST_SET (i == BIT_TXE)
            ) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .set_evt    (set_vec[i]),
                .stat_rd    (stat_rd),
                .clr_access (clr_vec[i]),
                .flag       (flag_vec[i])
            );
        end
    end

    assign status = flag_vec;

    uart_stat_irq u_irq (
        .status      (flag_vec),
        .ie_tx_empty (ie_tx_empty),
        .ie_tx_done  (ie_tx_done),
        .ie_rx_full  (ie_rx_full),
        .ie_rx_idle  (ie_rx_idle),
        .tx_irq      (tx_irq),
        .rx_irq      (rx_irq)
    );
endmodule

// File: rtl/uart_status_flags_chk.sv
module uart_status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_handoff,
    input logic       tx_active,
    input logic       rx_load,
    input logic       rx_overrun,
    input logic       data_rd,
    input logic       data_wr,
    input logic       ie_tx_empty,
    input logic       ie_rx_idle,
    input logic [7:0] status,
    input logic       tx_irq,
    input logic       rx_irq
);
    // R2
    txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_handoff |=> status[7]);

    // R3
    txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> $past(data_wr));

    // R4
    txc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !status[6]);

    // R5
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> status[5]);

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> status[3]);

    // R7
    rxf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[5]) |-> $past(data_rd));

    // R10
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && ie_tx_empty) |-> tx_irq);

    // R11
    rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && ie_rx_idle) |-> rx_irq);
endmodule

bind uart_status_flags uart_status_flags_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_handoff  (tx_handoff),
    .tx_active   (tx_active),
    .rx_load     (rx_load),
    .rx_overrun  (rx_overrun),
    .data_rd     (data_rd),
    .data_wr     (data_wr),
    .ie_tx_empty (ie_tx_empty),
    .ie_rx_idle  (ie_rx_idle),
    .status      (status),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq)
);

// File: tb/uart_status_flags_test.sv
`timescale 1ns/1ps
module uart_status_flags_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_handoff = 0, tx_active = 0, rx_load = 0, rx_noise = 0;
    logic rx_frame_err = 0, rx_parity_err = 0, rx_overrun = 0, rx_idle_det = 0;
    logic stat_rd = 0, data_rd = 0, data_wr = 0;
    logic ie_tx_empty = 0, ie_tx_done = 0, ie_rx_full = 0, ie_rx_idle = 0;
    logic [7:0] status;
    logic tx_irq, rx_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_status_flags uut (
        .clk(clk), .rst_n(rst_n), .tx_handoff(tx_handoff), .tx_active(tx_active),
        .rx_load(rx_load), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rx_overrun(rx_overrun), .rx_idle_det(rx_idle_det),
        .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .ie_tx_empty(ie_tx_empty), .ie_tx_done(ie_tx_done), .ie_rx_full(ie_rx_full),
        .ie_rx_idle(ie_rx_idle), .status(status), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // stim {txh txa rxl | nz fe pe ov idl | srd drd dwr}, ie {txe txc rxf idle},
    // expected status byte, expected {tx_irq, rx_irq}
    localparam int NV = 23;
    localparam logic [24:0] VEC [NV] = '{
        {11'b000_00000_000, 4'b0000, 8'b1100_0000, 2'b00}, // R1
        {11'b000_00000_000, 4'b1000, 8'b1100_0000, 2'b10}, // R10
        {11'b000_00000_001, 4'b0000, 8'b1100_0000, 2'b00}, // R8
        {11'b000_00000_100, 4'b0000, 8'b1100_0000, 2'b00}, // R3 arm
        {11'b010_00000_001, 4'b0100, 8'b0000_0000, 2'b00}, // R3 clear
        {11'b010_00000_000, 4'b0000, 8'b0000_0000, 2'b00}, // R4
        {11'b110_00000_000, 4'b0100, 8'b1000_0000, 2'b00}, // R2
        {11'b000_00000_000, 4'b0100, 8'b1100_0000, 2'b10}, // R4
        {11'b001_00100_000, 4'b0010, 8'b1110_0001, 2'b01}, // R5
        {11'b000_00000_010, 4'b0000, 8'b1110_0001, 2'b00}, // R8
        {11'b000_00000_100, 4'b0000, 8'b1110_0001, 2'b00}, // R7 arm
        {11'b001_00000_010, 4'b0000, 8'b1110_0000, 2'b00}, // R9
        {11'b000_00000_010, 4'b0000, 8'b1110_0000, 2'b00}, // R9
        {11'b000_00000_100, 4'b0000, 8'b1110_0000, 2'b00}, // R7
        {11'b000_00000_010, 4'b0000, 8'b1100_0000, 2'b00}, // R7
        {11'b000_00011_000, 4'b0001, 8'b1101_1000, 2'b01}, // R6 R11
        {11'b001_11000_000, 4'b0000, 8'b1111_1110, 2'b00}, // R5
        {11'b000_00000_100, 4'b0000, 8'b1111_1110, 2'b00}, // R7
        {11'b000_00000_001, 4'b0000, 8'b0011_1110, 2'b00}, // R3
        {11'b000_00000_010, 4'b0000, 8'b0000_0000, 2'b00}, // R7
        {11'b000_11100_000, 4'b0000, 8'b0000_0000, 2'b00}, // R5
        {11'b001_00000_100, 4'b0000, 8'b0010_0000, 2'b00}, // R9
        {11'b000_00000_010, 4'b0010, 8'b0010_0000, 2'b01}  // R9 R11
    };

    function automatic string req_of(int idx);
        case (idx)
            0: return "R1";   1: return "R10";  2: return "R8";   3: return "R3";
            4: return "R3";   5: return "R4";   6: return "R2";   7: return "R4";
            8: return "R5";   9: return "R8";   10: return "R7";  11: return "R9";
            12: return "R9";  13: return "R7";  14: return "R7";  15: return "R6";
            16: return "R5";  17: return "R7";  18: return "R3";  19: return "R7";
            20: return "R5";  21: return "R9";  default: return "R11";
        endcase
    endfunction

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {status,tx_irq,rx_irq} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(logic [10:0] s, logic [3:0] ie);
        {tx_handoff, tx_active, rx_load, rx_noise, rx_frame_err, rx_parity_err,
         rx_overrun, rx_idle_det, stat_rd, data_rd, data_wr} = s;
        {ie_tx_empty, ie_tx_done, ie_rx_full, ie_rx_idle} = ie;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check("R1", {status, tx_irq, rx_irq}, {8'hC0, 2'b00});

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][24:14], VEC[i][13:10]);
            @(posedge clk); #1;
            check(req_of(i), {status, tx_irq, rx_irq}, VEC[i][9:0]);
        end

        // R1: reset in the middle of activity restores the reset value
        drive(11'b001_11111_000, 4'b0000);
        @(posedge clk); #1;
        drive(11'b0, 4'b0000);
        rst_n = 1'b0;
        #1;
        check("R1", {status, tx_irq, rx_irq}, {8'hC0, 2'b00});
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R4: an active transmitter masks tx_done at once
        tx_active = 1'b1;
        #1;
        check("R4", {status, tx_irq, rx_irq}, {8'h80, 2'b00});
        // R11: rx_irq stays low with enables on and receive flags clear
        ie_rx_full = 1'b1; ie_rx_idle = 1'b1; ie_tx_done = 1'b1;
        #1;
        check("R11", {status, tx_irq, rx_irq}, {8'h80, 2'b00});
        tx_active = 1'b0;
        #1;
        // R10: tx_done alone with its enable raises tx_irq
        check("R10", {status, tx_irq, rx_irq}, {8'hC0, 2'b10});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule